// File: doc/BRIEF.md
# Integrating Switch Debouncer

This block cleans up a single mechanical push-button or switch signal. The raw input is first brought into the clock domain through a chain of synchronizing flops. It then drives an up/down counter that climbs on every cycle the switch reads as pressed and falls on every cycle it reads as released. The counter stops at zero and at a configurable ceiling. The clean level changes only when the counter arrives at one of those two ends. Contact bounce that never carries the count all the way across therefore leaves the output unchanged. Because the count must travel across the whole range between a press and the next release, the block has hysteresis.

Next to the clean level, the block gives a one-cycle strobe on each press and on each release, so downstream logic can act once per button action. The ceiling sets the settle time in clock cycles; a few milliseconds' worth of cycles is the usual choice. A polarity parameter lets an active-low switch be read as pressed while it is 0. Each button needs its own instance.

Top module: `debounce_integrator`

## Requirements
- R1: While reset is asserted and right after it is released, levelOut, pressPulse and releasePulse are 0 and the internal count is 0.
- R2: rawIn passes through two synchronizer flops before it reaches the counter. Start with the count at 0 and hold a pressed input from one clock edge onward. levelOut becomes 1 on the (CNT_MAX+3)th rising edge counted from that first edge.
- R3: The count never rises above CNT_MAX. After a pressed input has been held for any length of time, a held released input makes levelOut fall on the (CNT_MAX+3)th rising edge.
- R4: The count never falls below 0. After a released input has been held for any length of time, a held pressed input makes levelOut rise on the (CNT_MAX+3)th rising edge.
- R5: levelOut changes to 1 only in the cycle after the count equals CNT_MAX, and changes to 0 only in the cycle after the count equals 0. At every count in between it keeps its value, so bounce that does not carry the count to an end has no visible effect.
- R6: pressPulse is 1 for exactly one cycle, and it is 1 in the same cycle in which levelOut changes from 0 to 1.
- R7: releasePulse is 1 for exactly one cycle, and it is 1 in the same cycle in which levelOut changes from 1 to 0.
- R8: When ACTIVE_LOW is 1, a rawIn of 0 counts as pressed and a rawIn of 1 counts as released. When ACTIVE_LOW is 0, a rawIn of 1 counts as pressed.
- R9: Each cycle in which the synchronized input reads pressed, the count goes up by exactly 1 unless it is already at CNT_MAX. Each cycle in which it reads released, the count goes down by exactly 1 unless it is already at 0. A mixed input therefore reaches an end according to its net count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from a stable oscillator |
| rst | input | 1 | Asynchronous active-high reset |
| rawIn | input | 1 | Raw switch signal, possibly bouncing and asynchronous |
| levelOut | output | 1 | Debounced pressed level (1 = pressed) |
| pressPulse | output | 1 | One-cycle strobe when a press is recognised |
| releasePulse | output | 1 | One-cycle strobe when a release is recognised |

## Verification
The bench checks the exact latency from a clean edge of the input to the output. A design with a missing synchronizer stage or an extra register is off by a cycle. A design whose counter runs past the ceiling or wraps below zero shows a longer or erratic release or press delay after a long hold. Alternating and net-positive bounce patterns are applied both from the idle state and from the pressed state. A design that switches on an intermediate count, or resets its count on every change, toggles the level where it must hold, or switches too early or too late. A second instance with inverted polarity catches an inverted or ignored polarity setting. The pulse outputs are compared on every cycle, so a strobe that is stretched, repeated or missing is caught.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  // Strobes from control to the counter datapath
  typedef struct packed {
    logic up;
    logic down;
  } dbn_cmd_t;

  // Status from the datapath back to control
  typedef struct packed {
    logic sample;   // synchronized input, 1 = pressed
    logic atMax;    // count sits at the ceiling
    logic atZero;   // count sits at zero
  } dbn_stat_t;
endpackage

// File: rtl/dbn_datapath.sv
module dbn_datapath
  import dbn_pkg::*;
#(
  parameter int unsigned CNT_MAX    = 250000,
  parameter bit          ACTIVE_LOW = 1'b0,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rawIn,
  input  dbn_cmd_t  cmd,
  output dbn_stat_t stat
);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic        IDLE_RAW = ACTIVE_LOW;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  pressedS;
  logic [CNT_W-1:0]      cntQ;

  // Synchronizer chain, idle value follows polarity
  always_ff @(posedge clk or posedge rst) begin
    if (rst) syncQ <= {SYNC_DEPTH{IDLE_RAW}};
    else     syncQ <= {syncQ[SYNC_DEPTH-2:0], rawIn};
  end

  // Polarity variant picked at elaboration
  generate
    if (ACTIVE_LOW) begin : g_lowActive
      assign pressedS = ~syncQ[SYNC_DEPTH-1];
    end else begin : g_highActive
      assign pressedS = syncQ[SYNC_DEPTH-1];
    end
  endgenerate

  // Integrating counter, moves only on control strobes
  always_ff @(posedge clk or posedge rst) begin
    if (rst)           cntQ <= '0;
    else if (cmd.up)   cntQ <= cntQ + 1'b1;
    else if (cmd.down) cntQ <= cntQ - 1'b1;
  end

  always_comb begin
    stat.sample = pressedS;
    stat.atMax  = (cntQ == CNT_TOP);
    stat.atZero = (cntQ == '0);
  end

  // R9: one step per strobe
  p_up_step_r9: assert property (@(posedge clk) disable iff (rst)
    cmd.up |=> cntQ == $past(cntQ) + 1'b1);
  p_down_step_r9: assert property (@(posedge clk) disable iff (rst)
    cmd.down |=> cntQ == $past(cntQ) - 1'b1);
  // R3: pressed input at the ceiling stays there
  p_hold_top_r3: assert property (@(posedge clk) disable iff (rst)
    (stat.atMax && stat.sample) |=> stat.atMax);
  // R4: released input at zero stays there
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (stat.atZero && !stat.sample) |=> stat.atZero);
endmodule

// File: rtl/dbn_control.sv
module dbn_control
  import dbn_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dbn_stat_t stat,
  output dbn_cmd_t  cmd,
  output logic      levelQ,
  output logic      pressQ,
  output logic      releaseQ
);
  // Saturating step decisions
  always_comb begin
    cmd.up   = stat.sample  & ~stat.atMax;
    cmd.down = ~stat.sample & ~stat.atZero;
  end

  // Hysteretic level and edge strobes
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      levelQ   <= 1'b0;
      pressQ   <= 1'b0;
      releaseQ <= 1'b0;
    end else begin
      pressQ   <= stat.atMax  & ~levelQ;
      releaseQ <= stat.atZero &  levelQ;
      if (stat.atMax)       levelQ <= 1'b1;
      else if (stat.atZero) levelQ <= 1'b0;
    end
  end

  // R5: level moves only from an end of the range
  p_rise_at_top_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(levelQ) |-> $past(stat.atMax));
  p_fall_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(levelQ) |-> $past(stat.atZero));
  // R6 / R7: single-cycle strobes
  p_press_once_r6: assert property (@(posedge clk) disable iff (rst)
    pressQ |=> !pressQ);
  p_release_once_r7: assert property (@(posedge clk) disable iff (rst)
    releaseQ |=> !releaseQ);
endmodule

// File: rtl/debounce_integrator.sv
module debounce_integrator
  import dbn_pkg::*;
#(
  parameter int unsigned CNT_MAX    = 250000,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic levelOut,
  output logic pressPulse,
  output logic releasePulse
);
  localparam int unsigned SYNC_DEPTH = 2;

  dbn_cmd_t  cmd;
  dbn_stat_t stat;

  dbn_datapath #(
    .CNT_MAX(CNT_MAX), .ACTIVE_LOW(ACTIVE_LOW), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .rawIn(rawIn), .cmd(cmd), .stat(stat)
  );

  dbn_control u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .cmd(cmd),
    .levelQ(levelOut), .pressQ(pressPulse), .releaseQ(releasePulse)
  );

  // R6: a press strobe coincides with the level having just risen
  p_press_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    pressPulse |-> (levelOut && !$past(levelOut)));
  // R7: a release strobe coincides with the level having just fallen
  p_release_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    releasePulse |-> (!levelOut && $past(levelOut)));
endmodule

// File: tb/sim_debounce_integrator.sv
module sim_debounce_integrator;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_A = 6;   // active-high instance
  localparam int MAX_B = 4;   // active-low instance

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawA = 1'b0;
  logic rawB = 1'b1;
  logic lvlA, prsA, relA, lvlB, prsB, relB;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  debounce_integrator #(.CNT_MAX(MAX_A), .ACTIVE_LOW(1'b0)) u0 (
    .clk(clk), .rst(rst), .rawIn(rawA),
    .levelOut(lvlA), .pressPulse(prsA), .releasePulse(relA));
  debounce_integrator #(.CNT_MAX(MAX_B), .ACTIVE_LOW(1'b1)) u1 (
    .clk(clk), .rst(rst), .rawIn(rawB),
    .levelOut(lvlB), .pressPulse(prsB), .releasePulse(relB));

  // Behavioural reference: index 0 = u0, 1 = u1
  bit syncM[2][$];
  int cntM[2];
  bit lvlM[2], prsM[2], relM[2];

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      syncM[i] = {bit'(i), bit'(i)};
      cntM[i] = 0; lvlM[i] = 0; prsM[i] = 0; relM[i] = 0;
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (rst) modelReset();
    else begin
      for (int i = 0; i < 2; i++) begin
        int top;
        bit pressed, raw;
        top = (i == 0) ? MAX_A : MAX_B;
        raw = (i == 0) ? rawA : rawB;
        pressed = syncM[i][1] ^ bit'(i);
        prsM[i] = (cntM[i] == top) && !lvlM[i];
        relM[i] = (cntM[i] == 0) && lvlM[i];
        if (cntM[i] == top) lvlM[i] = 1;
        else if (cntM[i] == 0) lvlM[i] = 0;
        if (pressed && cntM[i] < top) cntM[i]++;
        else if (!pressed && cntM[i] > 0) cntM[i]--;
        syncM[i].push_front(raw);
        void'(syncM[i].pop_back());
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(lvlA == lvlM[0], "R5 level u0", lvlA, lvlM[0]);
      check(prsA == prsM[0], "R6 press u0", prsA, prsM[0]);
      check(relA == relM[0], "R7 release u0", relA, relM[0]);
      check(lvlB == lvlM[1], "R8 level u1", lvlB, lvlM[1]);
      check(prsB == prsM[1], "R8 press u1", prsB, prsM[1]);
      check(relB == relM[1], "R8 release u1", relB, relM[1]);
    end
  end

  task automatic drive(input bit a, input bit b);
    @(negedge clk);
    rawA = a; rawB = b;
  endtask

  // Cycles until u0 level reaches target, pulse checked at that point
  task automatic measureA(input bit target, output int n, output bit pulseSeen);
    n = 0;
    pulseSeen = 0;
    do begin
      @(negedge clk);
      n++;
    end while (lvlA != target && n < 100);
    pulseSeen = target ? prsA : relA;
  endtask

  task automatic measureB(input bit target, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (lvlB != target && n < 100);
  endtask

  initial begin
    int n;
    bit p;
    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    check(!lvlA && !prsA && !relA, "R1 reset u0", {lvlA, prsA, relA}, 0);
    check(!lvlB && !prsB && !relB, "R1 reset u1", {lvlB, prsB, relB}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!lvlA && !prsA && !relA, "R1 after reset u0", {lvlA, prsA, relA}, 0);

    // R2 / R4: clean press latency from zero
    drive(1, 1);
    measureA(1, n, p);
    check(n == MAX_A + 3, "R2 press latency", n, MAX_A + 3);
    check(p, "R6 press pulse at rise", p, 1);
    @(negedge clk);
    check(!prsA, "R6 press pulse single", prsA, 0);

    // R3: long hold then release latency
    repeat (30) drive(1, 1);
    drive(0, 1);
    measureA(0, n, p);
    check(n == MAX_A + 3, "R3 release latency after hold", n, MAX_A + 3);
    check(p, "R7 release pulse at fall", p, 1);
    @(negedge clk);
    check(!relA, "R7 release pulse single", relA, 0);

    // R4: long idle then press again
    repeat (30) drive(0, 1);
    drive(1, 1);
    measureA(1, n, p);
    check(n == MAX_A + 3, "R4 press latency after idle", n, MAX_A + 3);

    // R5: bounce while pressed keeps level high
    for (int k = 0; k < 20; k++) drive(k[0], 1);
    repeat (3) @(negedge clk);
    check(lvlA, "R5 level held through bounce", lvlA, 1);
    repeat (20) drive(0, 1);
    check(!lvlA, "R5 level low after settle", lvlA, 0);

    // R5: bounce from idle never reaches the ceiling
    for (int k = 0; k < 30; k++) drive(k[0], 1);
    check(!lvlA, "R5 bounce from idle ignored", lvlA, 0);

    // R9: net-positive pattern 1,1,0 climbs slowly
    for (int k = 0; k < 30; k++) drive((k % 3) != 2, 1);
    check(lvlA, "R9 net-positive pattern reaches top", lvlA, 1);
    repeat (20) drive(0, 1);

    // R8: active-low instance, 0 means pressed
    drive(0, 0);
    measureB(1, n);
    check(n == MAX_B + 3, "R8 active-low press latency", n, MAX_B + 3);
    repeat (10) drive(0, 0);
    drive(0, 1);
    measureB(0, n);
    check(n == MAX_B + 3, "R8 active-low release latency", n, MAX_B + 3);
    check(!lvlA, "R8 u0 unaffected while idle", lvlA, 0);

    // Mixed stimulus on both instances for the per-cycle model
    for (int k = 0; k < 200; k++) drive(((k * 7) % 5) < 3, ((k * 3) % 4) == 0);
    repeat (20) drive(0, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    done = 1'b1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule